// File: doc/BRIEF.md
# Banked Host Register Port

This block is the byte-wide host side of a network controller's register space. The host sees sixteen byte offsets. Most offsets change meaning with a bank number, which the host loads through a dedicated offset. Behind those offsets sit these 16-bit registers, each written one byte at a time:

- transmit control;
- receive control;
- configuration;
- general purpose;
- control;
- a packet-number byte;
- a buffer pointer.

The pointer turns four data offsets into byte accesses to a packet buffer RAM. The RAM is outside the block. The block drives its address and its strobes and takes back its read byte.

The buffer address is built from a page and a byte offset. The page comes either from the packet-number register or from the page at the head of the receive queue, and pointer bit 15 chooses between them. The byte offset is pointer bits 10:0. When pointer bit 14 is set, every data access moves the offset forward by one and wraps at the top of the page.

A write to the receive control high byte with bit 7 set starts a soft reset. The controller FSM has two states:

- `ST_RUN`: normal operation.
- `ST_SRST`: a single cycle in which every register returns to its reset value and host accesses are dropped.

`ST_RUN` moves to `ST_SRST` on that write (transition *soft_reset_req*). `ST_SRST` always returns to `ST_RUN` on the next clock (transition *restore_done*).

Top module: `banked_host_port`

## Requirements
- R1: A write to offset 14 loads the bank register with wdata bits 2:0, whatever the current bank. A read of offset 14 returns the bank in bits 2:0. Writes to offset 15 change nothing, and reads of offset 15 return 0.
- R2: In bank 0, offsets 0 and 1 are the low and high bytes of transmit control, and offsets 4 and 5 are the low and high bytes of receive control. A byte write changes only its own half.
- R3: A bank-0 write to offset 5 with wdata bit 7 set puts the block in `ST_SRST` for one cycle. In that cycle host writes have no effect and no buffer strobe is raised. From the next cycle every register holds its reset value.
- R4: In bank 1, offsets 0/1 hold configuration (reset value 0xA0B1), offsets 10/11 hold general purpose (reset value 0), and offsets 12/13 hold control (reset value 0x1210). Control bits 1:0 always read as 0.
- R5: In bank 2, offset 2 is the packet-number register and offsets 6/7 are the pointer's low and high bytes. Writes to offsets 3, 4 and 5 change neither of them.
- R6: In bank 2, a write to offsets 8–11 raises buf_we and a read raises buf_re in the same cycle. During that cycle buf_wdata equals host_wdata and buf_addr = {page, pointer[10:0]}. The page is rxq_head when pointer bit 15 is 1, otherwise packet-number bits 1:0.
- R7: With pointer bit 14 set, each data access increments pointer bits 10:0 modulo 2048, and bits 15:11 are unchanged. With bit 14 clear, the pointer is unchanged.
- R8: After rst_n, these all read 0: bank, transmit control, receive control and pointer. A read of bank 3 offset 12 returns 0x1F, the early-receive value.
- R9: Read data appears on host_rdata in the cycle after host_rd. A data read returns the byte the buffer delivered. Offsets that no register decodes read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host byte write strobe |
| host_rd | input | 1 | Host byte read strobe |
| host_addr | input | 4 | Byte offset |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, one cycle after host_rd |
| rxq_head | input | PAGE_W | Page at the head of the receive queue |
| buf_addr | output | PAGE_W+OFS_W | Packet buffer byte address |
| buf_we | output | 1 | Buffer write strobe |
| buf_re | output | 1 | Buffer read strobe |
| buf_wdata | output | 8 | Buffer write byte |
| buf_rdata | input | 8 | Buffer read byte, registered by the RAM |

## Verification
The bench builds the block with its default parameters: PAGE_W = 2 and OFS_W = 11. This gives a 13-bit buffer address. Both pages that sit at the top of the address, 1 and 3, can be selected, and the offset can be driven across its wrap from 0x7FF to 0x000 in three accesses. With these values, every bank decoded by the port, the pointer's page selection and the soft-reset cycle are all reachable from the byte-level host interface alone.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
    typedef enum logic {ST_RUN = 1'b0, ST_SRST = 1'b1} hrp_state_e;

    localparam int          BANK_W  = 3;
    localparam logic [15:0] CFG_RST = 16'hA0B1;
    localparam logic [15:0] CTL_RST = 16'h1210;
    localparam logic [7:0]  ERX_VAL = 8'h1F;
endpackage

// File: rtl/hrp_ctrl.sv
module hrp_ctrl
    import hrp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic srst_req,
    output logic acc_ok,
    output logic soft_clr
);
    hrp_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (srst_req) state_d = ST_SRST;   // soft_reset_req
            ST_SRST: state_d = ST_RUN;                  // restore_done
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        acc_ok   = (state_q == ST_RUN);
        soft_clr = (state_q == ST_SRST);
    end

    AST_SRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SRST) |=> (state_q == ST_RUN)); // R3
endmodule

// File: rtl/hrp_regfile.sv
module hrp_regfile
    import hrp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [3:0]        addr,
    input  logic [7:0]        wdata,
    output logic [BANK_W-1:0] bank,
    output logic [7:0]        pktnum,
    output logic [7:0]        reg_rd
);
    logic [BANK_W-1:0] bank_q;
    logic [15:0]       tcr_q, rcr_q, cfg_q, gpr_q, ctl_q;
    logic [7:0]        pkt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0; tcr_q <= '0; rcr_q <= '0;
            cfg_q  <= CFG_RST; gpr_q <= '0; ctl_q <= CTL_RST; pkt_q <= '0;
        end else if (clr) begin
            bank_q <= '0; tcr_q <= '0; rcr_q <= '0;
            cfg_q  <= CFG_RST; gpr_q <= '0; ctl_q <= CTL_RST; pkt_q <= '0;
        end else if (wr) begin
            if (addr == 4'd14) begin
                bank_q <= wdata[BANK_W-1:0];
            end else if (addr != 4'd15) begin
                case (bank_q)
                    3'd0: case (addr)
                        4'd0:    tcr_q[7:0]  <= wdata;
                        4'd1:    tcr_q[15:8] <= wdata;
                        4'd4:    rcr_q[7:0]  <= wdata;
                        4'd5:    rcr_q[15:8] <= wdata;
                        default: ;
                    endcase
                    3'd1: case (addr)
                        4'd0:    cfg_q[7:0]  <= wdata;
                        4'd1:    cfg_q[15:8] <= wdata;
                        4'd10:   gpr_q[7:0]  <= wdata;
                        4'd11:   gpr_q[15:8] <= wdata;
                        4'd12:   ctl_q[7:0]  <= {wdata[7:2], 2'b00};
                        4'd13:   ctl_q[15:8] <= wdata;
                        default: ;
                    endcase
                    3'd2: if (addr == 4'd2) pkt_q <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        reg_rd = '0;
        if (addr == 4'd14) begin
            reg_rd = {{(8-BANK_W){1'b0}}, bank_q};
        end else if (addr != 4'd15) begin
            case (bank_q)
                3'd0: case (addr)
                    4'd0:    reg_rd = tcr_q[7:0];
                    4'd1:    reg_rd = tcr_q[15:8];
                    4'd4:    reg_rd = rcr_q[7:0];
                    4'd5:    reg_rd = rcr_q[15:8];
                    default: ;
                endcase
                3'd1: case (addr)
                    4'd0:    reg_rd = cfg_q[7:0];
                    4'd1:    reg_rd = cfg_q[15:8];
                    4'd10:   reg_rd = gpr_q[7:0];
                    4'd11:   reg_rd = gpr_q[15:8];
                    4'd12:   reg_rd = ctl_q[7:0];
                    4'd13:   reg_rd = ctl_q[15:8];
                    default: ;
                endcase
                3'd2: if (addr == 4'd2) reg_rd = pkt_q;
                3'd3: if (addr == 4'd12) reg_rd = ERX_VAL;
                default: ;
            endcase
        end
    end

    assign bank   = bank_q;
    assign pktnum = pkt_q;

    AST_CTL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[1:0] == 2'b00); // R4
    AST_SRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (bank_q == '0 && rcr_q == '0 && cfg_q == CFG_RST && ctl_q == CTL_RST)); // R3
    AST_OFS15_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr && addr == 4'd15) |=> ($stable(bank_q) && $stable(tcr_q) && $stable(cfg_q))); // R1
endmodule

// File: rtl/hrp_ptr.sv
module hrp_ptr #(
    parameter int PAGE_W = 2,
    parameter int OFS_W  = 11,
    localparam int AW    = PAGE_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [7:0]        wdata,
    input  logic              acc,
    input  logic [PAGE_W-1:0] rx_page,
    input  logic [PAGE_W-1:0] pk_page,
    output logic [15:0]       ptr,
    output logic [AW-1:0]     addr
);
    localparam logic [OFS_W-1:0] STEP = OFS_W'(1);

    logic [15:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  ptr_q <= '0;
        else if (clr)                ptr_q <= '0;
        else if (wr_lo)              ptr_q[7:0]  <= wdata;
        else if (wr_hi)              ptr_q[15:8] <= wdata;
        else if (acc && ptr_q[14])   ptr_q[OFS_W-1:0] <= ptr_q[OFS_W-1:0] + STEP;
    end

    assign ptr  = ptr_q;
    assign addr = {(ptr_q[15] ? rx_page : pk_page), ptr_q[OFS_W-1:0]};

    AST_PTR_TOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !clr && !wr_lo && !wr_hi) |=> (ptr_q[15:OFS_W] == $past(ptr_q[15:OFS_W]))); // R7
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !clr && ptr_q[14]) |=> (ptr_q[OFS_W-1:0] == $past(ptr_q[OFS_W-1:0]) + STEP)); // R7
endmodule

// File: rtl/banked_host_port.sv
module banked_host_port
    import hrp_pkg::*;
#(
    parameter int PAGE_W = 2,
    parameter int OFS_W  = 11,
    localparam int AW    = PAGE_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [3:0]        host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic [PAGE_W-1:0] rxq_head,
    output logic [AW-1:0]     buf_addr,
    output logic              buf_we,
    output logic              buf_re,
    output logic [7:0]        buf_wdata,
    input  logic [7:0]        buf_rdata
);
    logic              acc_ok, soft_clr, srst_req;
    logic              acc_wr, acc_rd, in_b2, data_off;
    logic [BANK_W-1:0] bank;
    logic [7:0]        pktnum, reg_rd, rd_mux, rd_q;
    logic [15:0]       ptr;
    logic              data_sel_q;

    assign acc_wr   = host_wr && acc_ok;
    assign acc_rd   = host_rd && acc_ok;
    assign in_b2    = (bank == 3'd2);
    assign data_off = (host_addr[3:2] == 2'b10);
    assign srst_req = acc_wr && (bank == 3'd0) && (host_addr == 4'd5) && host_wdata[7];
    assign buf_we   = acc_wr && in_b2 && data_off;
    assign buf_re   = acc_rd && in_b2 && data_off;
    assign buf_wdata = host_wdata;

    hrp_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .srst_req(srst_req),
        .acc_ok(acc_ok), .soft_clr(soft_clr)
    );

    hrp_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr), .wr(acc_wr),
        .addr(host_addr), .wdata(host_wdata),
        .bank(bank), .pktnum(pktnum), .reg_rd(reg_rd)
    );

    hrp_ptr #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr),
        .wr_lo(acc_wr && in_b2 && host_addr == 4'd6),
        .wr_hi(acc_wr && in_b2 && host_addr == 4'd7),
        .wdata(host_wdata), .acc(buf_we || buf_re),
        .rx_page(rxq_head), .pk_page(pktnum[PAGE_W-1:0]),
        .ptr(ptr), .addr(buf_addr)
    );

    always_comb begin
        rd_mux = reg_rd;
        if (in_b2 && host_addr == 4'd6) rd_mux = ptr[7:0];
        if (in_b2 && host_addr == 4'd7) rd_mux = ptr[15:8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q       <= '0;
            data_sel_q <= 1'b0;
        end else if (acc_rd) begin
            rd_q       <= rd_mux;
            data_sel_q <= buf_re;
        end
    end

    assign host_rdata = data_sel_q ? buf_rdata : rd_q;

    AST_NO_BUF_IN_SRST: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |-> (!buf_we && !buf_re)); // R3
    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_we && buf_re) || (host_wr && host_rd)); // R6
endmodule

// File: tb/banked_host_port_test.sv
module banked_host_port_test;
    localparam int CLK_P = 10;
    localparam int NV    = 33;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [1:0]  rxq_head = 2'd3;
    logic [12:0] buf_addr;
    logic        buf_we, buf_re;
    logic [7:0]  buf_wdata;
    logic [7:0]  buf_rdata = '0;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    banked_host_port uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rxq_head(rxq_head), .buf_addr(buf_addr), .buf_we(buf_we), .buf_re(buf_re),
        .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
    );

    function automatic logic [7:0] ram_val(input logic [12:0] a);
        return a[7:0] ^ {3'b000, a[12:8]};
    endfunction

    always @(posedge clk) if (buf_re) buf_rdata <= ram_val(buf_addr);

    // {rd, addr, data, expected, requirement}
    localparam logic [24:0] VT [0:NV-1] = '{
        {1'b0, 4'd0,  8'h5A, 8'h00, 4'd2},  // R2 tcr low
        {1'b0, 4'd1,  8'h3C, 8'h00, 4'd2},
        {1'b1, 4'd0,  8'h00, 8'h5A, 4'd2},
        {1'b1, 4'd1,  8'h00, 8'h3C, 4'd2},
        {1'b0, 4'd4,  8'h11, 8'h00, 4'd2},  // R2 rcr low only
        {1'b1, 4'd4,  8'h00, 8'h11, 4'd2},
        {1'b1, 4'd5,  8'h00, 8'h00, 4'd2},
        {1'b1, 4'd0,  8'h00, 8'h5A, 4'd2},
        {1'b0, 4'd14, 8'h01, 8'h00, 4'd1},  // R1 bank 1
        {1'b1, 4'd14, 8'h00, 8'h01, 4'd1},
        {1'b1, 4'd0,  8'h00, 8'hB1, 4'd4},  // R4 config reset
        {1'b1, 4'd1,  8'h00, 8'hA0, 4'd4},
        {1'b1, 4'd12, 8'h00, 8'h10, 4'd4},  // R4 control reset
        {1'b1, 4'd13, 8'h00, 8'h12, 4'd4},
        {1'b0, 4'd12, 8'hFF, 8'h00, 4'd4},
        {1'b1, 4'd12, 8'h00, 8'hFC, 4'd4},  // R4 bits 1:0 forced low
        {1'b1, 4'd13, 8'h00, 8'h12, 4'd4},
        {1'b0, 4'd10, 8'h77, 8'h00, 4'd4},
        {1'b1, 4'd10, 8'h00, 8'h77, 4'd4},
        {1'b1, 4'd11, 8'h00, 8'h00, 4'd4},
        {1'b0, 4'd15, 8'h02, 8'h00, 4'd1},  // R1 offset 15 ignored
        {1'b1, 4'd14, 8'h00, 8'h01, 4'd1},
        {1'b1, 4'd15, 8'h00, 8'h00, 4'd1},
        {1'b1, 4'd4,  8'h00, 8'h00, 4'd9},  // R9 undecoded reads zero
        {1'b0, 4'd14, 8'h03, 8'h00, 4'd1},
        {1'b1, 4'd12, 8'h00, 8'h1F, 4'd8},  // R8 early-receive value
        {1'b1, 4'd13, 8'h00, 8'h00, 4'd9},
        {1'b0, 4'd14, 8'h00, 8'h00, 4'd1},
        {1'b1, 4'd0,  8'h00, 8'h5A, 4'd2},
        {1'b0, 4'd14, 8'h05, 8'h00, 4'd1},
        {1'b1, 4'd14, 8'h00, 8'h05, 4'd1},
        {1'b1, 4'd0,  8'h00, 8'h00, 4'd9},
        {1'b0, 4'd14, 8'h00, 8'h00, 4'd1}
    };

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(posedge clk); #1;
        host_rd = 1'b0;
        @(negedge clk);
        check(host_rdata === e, tag, {8'h0, host_rdata}, {8'h0, e});
    endtask

    task automatic data_wr(input logic [3:0] a, input logic [7:0] d, input logic [12:0] ea, input string tag);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        #1;
        check(buf_we === 1'b1 && buf_addr === ea && buf_wdata === d, tag,
              {2'b0, buf_we, buf_addr}, {3'b001, ea});
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8 reset state
        @(negedge clk);
        check(buf_we === 1'b0 && buf_re === 1'b0, "R8 strobes idle", {14'h0, buf_we, buf_re}, 16'h0);
        rd_chk(4'd14, 8'h00, "R8 bank");
        rd_chk(4'd1,  8'h00, "R8 tcr");
        rd_chk(4'd5,  8'h00, "R8 rcr");

        for (int i = 0; i < NV; i++) begin
            if (VT[i][24]) begin
                @(negedge clk);
                host_rd = 1'b1; host_addr = VT[i][23:20];
                @(posedge clk); #1;
                host_rd = 1'b0;
                @(negedge clk);
                checks++;
                if (host_rdata !== VT[i][11:4]) begin
                    errors++;
                    $display("FAIL R%0d vector %0d actual=%h expected=%h",
                             VT[i][3:0], i, host_rdata, VT[i][11:4]);
                end
            end else begin
                wr(VT[i][23:20], VT[i][19:12]);
            end
        end

        // Bank 2: pointer, pages, auto-increment wrap
        wr(4'd14, 8'h02);
        rd_chk(4'd6, 8'h00, "R8 pointer low");
        wr(4'd2, 8'h01);
        wr(4'd6, 8'hFE);
        wr(4'd7, 8'h47);
        rd_chk(4'd2, 8'h01, "R5 packet number");
        rd_chk(4'd7, 8'h47, "R5 pointer high");
        data_wr(4'd8,  8'hAB, 13'h0FFE, "R6 data write addr");
        data_wr(4'd11, 8'hCD, 13'h0FFF, "R7 increment");
        data_wr(4'd10, 8'hEF, 13'h0800, "R7 wrap keeps page");
        rd_chk(4'd6, 8'h01, "R7 offset after wrap");
        rd_chk(4'd7, 8'h40, "R7 top bits held");

        // receive-queue page, no auto-increment
        wr(4'd7, 8'h80);
        @(negedge clk);
        host_rd = 1'b1; host_addr = 4'd9;
        #1;
        check(buf_re === 1'b1 && buf_addr === 13'h1801, "R6 rx page addr",
              {2'b0, buf_re, buf_addr}, {3'b001, 13'h1801});
        @(posedge clk); #1;
        host_rd = 1'b0;
        @(negedge clk);
        check(host_rdata === ram_val(13'h1801), "R9 data read", {8'h0, host_rdata}, {8'h0, ram_val(13'h1801)});
        rd_chk(4'd6, 8'h01, "R7 no increment");
        rd_chk(4'd7, 8'h80, "R7 no increment high");

        // offsets 3..5 ignored
        wr(4'd3, 8'h55);
        wr(4'd4, 8'h66);
        wr(4'd5, 8'h77);
        rd_chk(4'd2, 8'h01, "R5 packet number kept");
        rd_chk(4'd6, 8'h01, "R5 pointer kept");

        // soft reset
        wr(4'd14, 8'h00);
        wr(4'd5, 8'h80);
        wr(4'd0, 8'h99);   // falls in the soft-reset cycle
        rd_chk(4'd0,  8'h00, "R3 write dropped, tcr reset");
        rd_chk(4'd5,  8'h00, "R3 rcr reset");
        rd_chk(4'd14, 8'h00, "R3 bank reset");
        wr(4'd14, 8'h01);
        rd_chk(4'd1,  8'hA0, "R3 config reset");
        rd_chk(4'd10, 8'h00, "R3 gpr reset");
        wr(4'd14, 8'h02);
        rd_chk(4'd2,  8'h00, "R3 packet number reset");
        rd_chk(4'd7,  8'h00, "R3 pointer reset");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule